// File: doc/BRIEF.md
# Video DAC Output Data Multiplexer

This block sits just before three 11-bit video DAC channels and picks, for every sample, what code each channel receives. A sample is taken either from the incoming three-channel video bus or from levels held in configuration inputs. Those levels are one blank, one sync-low and one sync-high value for luma, and the same three for the chroma pair. The choice depends on the display mode, the line type and active-video flag reported by the timing generator, and a passthrough enable that lets chosen non-video line types still carry picture data during their active portion.

Video samples can receive a programmable sync-headroom offset, with saturation at full scale. The offset goes on all three channels for RGB output. For component YPbPr output it goes only on luma, because the two colour-difference channels are offset binary and start at code 0. A bypass setting forwards input codes to the DACs untouched. All configuration is captured into shadow registers on a frame-start pulse, so a change never takes effect in the middle of a frame. Every DAC code is registered.

Top module: `vdac_outmux`

## Requirements
- R1: While `rst` is high, every `dac_out` channel is 0. After reset, the shadow configuration is PC-graphics mode, YPbPr, bypass off and offset 0, and it stays so until the first `frame_start`.
- R2: A change on the inputs appears on `dac_out` exactly one clock edge later. It does not appear before that edge.
- R3: In PC-graphics mode (mode code 0), every channel is driven from `vid_in`, whatever the line type, active flag or level selector.
- R4: In mode codes 1 (SD), 2 (HD) and 3 (treated as SD), a video line type (codes 0 and 1 with the default mask) carries `vid_in` when `active` is 1. When `active` is 0, it carries the programmed levels.
- R5: In modes 1 to 3, a non-video line type carries the programmed levels. There is one exception: `vid_in` is passed when passthrough is enabled, `active` is 1 and the line type is passthrough-capable (codes 4 and 5 with the default mask).
- R6: When levels are driven, `lvl_sel` selects them: 0 gives blank, 1 gives sync-low, 2 gives sync-high and 3 gives blank. Channel 0 takes the luma set and channels 1 and 2 take the chroma set. No offset is added to a level.
- R7: For video samples with bypass off, the offset is added to channel 0 always. It is added to channels 1 and 2 only when `cfg_rgb` is 1.
- R8: An offset sum above 2047 is clamped to 2047 and never wraps.
- R9: With bypass on, video samples reach the DACs unchanged on every channel. Source selection is not affected.
- R10: Configuration inputs take effect only from the clock edge at which `frame_start` is 1. Changes between pulses have no effect on `dac_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame-start pulse from timing generator; loads shadow configuration |
| vid_in | input | 3x11 | Video samples, channel 0 is luma/G |
| line_type | input | 3 | Current line type from timing generator |
| active | input | 1 | Active-video portion of the line |
| lvl_sel | input | 2 | Level selector: 0 blank, 1 sync-low, 2 sync-high, 3 blank |
| cfg_mode | input | 2 | 0 PC graphics, 1 SD, 2 HD, 3 as SD |
| cfg_pass | input | 1 | Passthrough enable |
| cfg_rgb | input | 1 | 1 RGB output, 0 YPbPr output |
| cfg_bypass | input | 1 | Forward video codes with no offset |
| cfg_offset | input | 11 | Sync-headroom offset |
| cfg_y_blank | input | 11 | Luma blank level |
| cfg_y_synclo | input | 11 | Luma sync-low level |
| cfg_y_synchi | input | 11 | Luma sync-high level |
| cfg_c_blank | input | 11 | Chroma blank level |
| cfg_c_synclo | input | 11 | Chroma sync-low level |
| cfg_c_synchi | input | 11 | Chroma sync-high level |
| dac_out | output | 3x11 | Registered DAC codes |

## Verification
The hardest case to reach is the one where several conditions meet: video passes on a non-video line only under a timing-generator mode with passthrough on, the active flag high and a passthrough-capable line type. Its outcome then depends on offset, RGB and bypass settings that only load at a frame pulse. The stimulus loops over every combination of shadowed configuration, issuing a frame pulse per combination. Under each one it walks all line types, both active values and all four level codes, with video values spread so that offset sums cross the clamp. Separate sequences change configuration without a pulse, and place sums right at 2046 and 2047.

// File: rtl/vdac_pkg.sv
package vdac_pkg;
  typedef enum logic [1:0] {
    MD_PC  = 2'd0,
    MD_SD  = 2'd1,
    MD_HD  = 2'd2,
    MD_RSV = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    LV_BLANK = 2'd0,
    LV_SLO   = 2'd1,
    LV_SHI   = 2'd2,
    LV_RSV   = 2'd3
  } lvl_e;

  localparam int NLVL = 3;
endpackage

// File: rtl/vdac_cfg_shadow.sv
module vdac_cfg_shadow
  import vdac_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [1:0]               mode_in,
  input  logic                     pass_in,
  input  logic                     rgb_in,
  input  logic                     byp_in,
  input  logic [CW-1:0]            off_in,
  input  logic [NLVL-1:0][CW-1:0]  ylv_in,
  input  logic [NLVL-1:0][CW-1:0]  clv_in,
  output logic [1:0]               mode_q,
  output logic                     pass_q,
  output logic                     rgb_q,
  output logic                     byp_q,
  output logic [CW-1:0]            off_q,
  output logic [NLVL-1:0][CW-1:0]  ylv_q,
  output logic [NLVL-1:0][CW-1:0]  clv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_PC;
      pass_q <= 1'b0;
      rgb_q  <= 1'b0;
      byp_q  <= 1'b0;
      off_q  <= '0;
      ylv_q  <= '0;
      clv_q  <= '0;
    end else if (load) begin
      mode_q <= mode_in;
      pass_q <= pass_in;
      rgb_q  <= rgb_in;
      byp_q  <= byp_in;
      off_q  <= off_in;
      ylv_q  <= ylv_in;
      clv_q  <= clv_in;
    end
  end
endmodule

// File: rtl/vdac_src_sel.sv
module vdac_src_sel
  import vdac_pkg::*;
#(
  parameter int LT_W = 3,
  parameter logic [(1<<LT_W)-1:0] VID_LT_MASK  = 8'h03,
  parameter logic [(1<<LT_W)-1:0] PASS_LT_MASK = 8'h30
) (
  input  logic [1:0]      mode,
  input  logic            pass_en,
  input  logic [LT_W-1:0] line_type,
  input  logic            active,
  input  logic [1:0]      lvl_sel,
  output logic            use_video,
  output logic [1:0]      lvl_idx
);
  logic is_pc;
  logic vid_line;
  logic pass_line;

  always_comb begin
    is_pc     = (mode == MD_PC);
    vid_line  = VID_LT_MASK[line_type];
    pass_line = pass_en && PASS_LT_MASK[line_type];
    use_video = is_pc || (active && (vid_line || pass_line));
    lvl_idx   = (lvl_sel == LV_RSV) ? LV_BLANK : lvl_sel;
  end
endmodule

// File: rtl/vdac_chan.sv
module vdac_chan #(
  parameter int CW = 11,
  parameter bit LUMA = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] vid,
  input  logic [CW-1:0] offset,
  input  logic          rgb,
  input  logic          bypass,
  input  logic          use_video,
  input  logic [CW-1:0] level,
  output logic [CW-1:0] dac
);
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic          add_en;
  logic [CW:0]   sum;
  logic [CW-1:0] vid_adj;
  logic [CW-1:0] nxt;

  always_comb begin
    add_en  = !bypass && (LUMA || rgb);
    sum     = {1'b0, vid} + {1'b0, (add_en ? offset : '0)};
    vid_adj = sum[CW] ? FULL : sum[CW-1:0];
    nxt     = use_video ? vid_adj : level;
  end

  always_ff @(posedge clk) begin
    if (rst) dac <= '0;
    else     dac <= nxt;
  end
endmodule

// File: rtl/vdac_outmux.sv
module vdac_outmux
  import vdac_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int CW   = 11,
  parameter int LT_W = 3,
  parameter logic [(1<<LT_W)-1:0] VID_LT_MASK  = 8'h03,
  parameter logic [(1<<LT_W)-1:0] PASS_LT_MASK = 8'h30
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_start,
  input  logic [NCH-1:0][CW-1:0]  vid_in,
  input  logic [LT_W-1:0]         line_type,
  input  logic                    active,
  input  logic [1:0]              lvl_sel,
  input  logic [1:0]              cfg_mode,
  input  logic                    cfg_pass,
  input  logic                    cfg_rgb,
  input  logic                    cfg_bypass,
  input  logic [CW-1:0]           cfg_offset,
  input  logic [CW-1:0]           cfg_y_blank,
  input  logic [CW-1:0]           cfg_y_synclo,
  input  logic [CW-1:0]           cfg_y_synchi,
  input  logic [CW-1:0]           cfg_c_blank,
  input  logic [CW-1:0]           cfg_c_synclo,
  input  logic [CW-1:0]           cfg_c_synchi,
  output logic [NCH-1:0][CW-1:0]  dac_out
);
  logic [NLVL-1:0][CW-1:0] ylv_in, clv_in;
  logic [NLVL-1:0][CW-1:0] sh_ylv, sh_clv;
  logic [1:0]              sh_mode;
  logic                    sh_pass, sh_rgb, sh_bypass;
  logic [CW-1:0]           sh_off;
  logic                    use_video;
  logic [1:0]              lvl_idx;

  always_comb begin
    ylv_in[LV_BLANK] = cfg_y_blank;
    ylv_in[LV_SLO]   = cfg_y_synclo;
    ylv_in[LV_SHI]   = cfg_y_synchi;
    clv_in[LV_BLANK] = cfg_c_blank;
    clv_in[LV_SLO]   = cfg_c_synclo;
    clv_in[LV_SHI]   = cfg_c_synchi;
  end

  vdac_cfg_shadow #(.CW(CW)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .load    (frame_start),
    .mode_in (cfg_mode),
    .pass_in (cfg_pass),
    .rgb_in  (cfg_rgb),
    .byp_in  (cfg_bypass),
    .off_in  (cfg_offset),
    .ylv_in  (ylv_in),
    .clv_in  (clv_in),
    .mode_q  (sh_mode),
    .pass_q  (sh_pass),
    .rgb_q   (sh_rgb),
    .byp_q   (sh_bypass),
    .off_q   (sh_off),
    .ylv_q   (sh_ylv),
    .clv_q   (sh_clv)
  );

  vdac_src_sel #(
    .LT_W         (LT_W),
    .VID_LT_MASK  (VID_LT_MASK),
    .PASS_LT_MASK (PASS_LT_MASK)
  ) u_sel (
    .mode      (sh_mode),
    .pass_en   (sh_pass),
    .line_type (line_type),
    .active    (active),
    .lvl_sel   (lvl_sel),
    .use_video (use_video),
    .lvl_idx   (lvl_idx)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CW-1:0] lvl_val;
    if (ch == 0) begin : g_luma
      assign lvl_val = sh_ylv[lvl_idx];
    end else begin : g_chroma
      assign lvl_val = sh_clv[lvl_idx];
    end
    vdac_chan #(.CW(CW), .LUMA(ch == 0)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .vid       (vid_in[ch]),
      .offset    (sh_off),
      .rgb       (sh_rgb),
      .bypass    (sh_bypass),
      .use_video (use_video),
      .level     (lvl_val),
      .dac       (dac_out[ch])
    );
  end
endmodule

// File: rtl/vdac_outmux_chk.sv
module vdac_outmux_chk #(
  parameter int NCH = 3,
  parameter int CW  = 11
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   frame_start,
  input logic [NCH-1:0][CW-1:0] vid_in,
  input logic [NCH-1:0][CW-1:0] dac_out,
  input logic [1:0]             lvl_sel,
  input logic                   use_video,
  input logic [1:0]             sh_mode,
  input logic                   sh_rgb,
  input logic                   sh_bypass,
  input logic [2:0][CW-1:0]     sh_ylv
);
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (dac_out == '0));

  a_r3_pc_direct: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && sh_mode == 2'd0 && sh_bypass) |-> (dac_out == $past(vid_in)));

  a_r6_sync_low_luma: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !use_video && lvl_sel == 2'd1) |-> (dac_out[0] == $past(sh_ylv[1])));

  a_r7_chroma_plain: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && use_video && !sh_rgb) |-> (dac_out[1] == $past(vid_in[1])));

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && use_video && !sh_bypass) |-> (dac_out[0] >= $past(vid_in[0])));

  a_r10_hold_cfg: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(sh_mode) && $stable(sh_rgb) && $stable(sh_bypass)));
endmodule

bind vdac_outmux vdac_outmux_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .vid_in      (vid_in),
  .dac_out     (dac_out),
  .lvl_sel     (lvl_sel),
  .use_video   (use_video),
  .sh_mode     (sh_mode),
  .sh_rgb      (sh_rgb),
  .sh_bypass   (sh_bypass),
  .sh_ylv      (sh_ylv)
);

// File: tb/sim_vdac_outmux.sv
`timescale 1ns/1ps
module sim_vdac_outmux;
  localparam int NCH = 3;
  localparam int CW  = 11;
  localparam logic [7:0] VIDM  = 8'h03;
  localparam logic [7:0] PASSM = 8'h30;

  logic clk = 1'b0;
  logic rst;
  logic frame_start;
  logic [NCH-1:0][CW-1:0] vid_in;
  logic [2:0] line_type;
  logic active;
  logic [1:0] lvl_sel;
  logic [1:0] cfg_mode;
  logic cfg_pass, cfg_rgb, cfg_bypass;
  logic [CW-1:0] cfg_offset;
  logic [CW-1:0] yb, ysl, ysh, cb, csl, csh;
  logic [NCH-1:0][CW-1:0] dac_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  vdac_outmux u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .vid_in(vid_in),
    .line_type(line_type), .active(active), .lvl_sel(lvl_sel),
    .cfg_mode(cfg_mode), .cfg_pass(cfg_pass), .cfg_rgb(cfg_rgb),
    .cfg_bypass(cfg_bypass), .cfg_offset(cfg_offset),
    .cfg_y_blank(yb), .cfg_y_synclo(ysl), .cfg_y_synchi(ysh),
    .cfg_c_blank(cb), .cfg_c_synclo(csl), .cfg_c_synchi(csh),
    .dac_out(dac_out)
  );

  task automatic check(input string tag, input logic [NCH-1:0][CW-1:0] exp);
    n_chk++;
    if (dac_out !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, dac_out, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_frame();
    frame_start = 1'b1;
    step();
    frame_start = 1'b0;
  endtask

  function automatic logic [CW-1:0] model(input int ch, input logic [1:0] md,
      input logic ps, input logic rg, input logic bp, input logic [CW-1:0] off,
      input logic [2:0] lt, input logic ac, input logic [1:0] lv,
      input logic [CW-1:0] v, input logic [CW-1:0] yl0, input logic [CW-1:0] yl1,
      input logic [CW-1:0] yl2, input logic [CW-1:0] cl0, input logic [CW-1:0] cl1,
      input logic [CW-1:0] cl2);
    logic usev;
    int s;
    usev = (md == 2'd0) || (ac && (VIDM[lt] || (ps && PASSM[lt])));
    if (usev) begin
      if (bp) return v;
      if (ch == 0 || rg) begin
        s = int'(v) + int'(off);
        return (s > 2047) ? 11'd2047 : CW'(s);
      end
      return v;
    end
    if (lv == 2'd1) return (ch == 0) ? yl1 : cl1;
    if (lv == 2'd2) return (ch == 0) ? yl2 : cl2;
    return (ch == 0) ? yl0 : cl0;
  endfunction

  function automatic logic [NCH-1:0][CW-1:0] model_all();
    logic [NCH-1:0][CW-1:0] r;
    for (int c = 0; c < NCH; c++)
      r[c] = model(c, cfg_mode, cfg_pass, cfg_rgb, cfg_bypass, cfg_offset,
                   line_type, active, lvl_sel, vid_in[c], yb, ysl, ysh, cb, csl, csh);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NCH-1:0][CW-1:0] exp, prev;
    int k;
    string tag;
    rst = 1'b1; frame_start = 1'b0; vid_in = '0; line_type = '0; active = 1'b0;
    lvl_sel = '0; cfg_mode = 2'd1; cfg_pass = 1'b0; cfg_rgb = 1'b0; cfg_bypass = 1'b0;
    cfg_offset = 11'd300;
    yb = 11'd64; ysl = 11'd4; ysh = 11'd900; cb = 11'd512; csl = 11'd16; csh = 11'd1000;
    vid_in[0] = 11'd5; vid_in[1] = 11'd6; vid_in[2] = 11'd7;
    repeat (3) step();
    check("R1 reset", '0);
    rst = 1'b0;
    line_type = 3'd7; active = 1'b0; lvl_sel = 2'd1;
    step();
    // R1: default shadow is PC mode, offset 0, although inputs request SD
    check("R1 default cfg", vid_in);

    // R2: new input not visible before the edge, visible after it
    prev = dac_out;
    vid_in[0] = 11'd111; vid_in[1] = 11'd222; vid_in[2] = 11'd333;
    #1;
    check("R2 before edge", prev);
    @(negedge clk);
    check("R2 after edge", {11'd333, 11'd222, 11'd111});

    // Full sweep of shadowed configuration x line type x active x level
    k = 0;
    for (int md = 0; md < 4; md++)
      for (int ps = 0; ps < 2; ps++)
        for (int rg = 0; rg < 2; rg++)
          for (int bp = 0; bp < 2; bp++) begin
            cfg_mode = md[1:0]; cfg_pass = ps[0]; cfg_rgb = rg[0]; cfg_bypass = bp[0];
            pulse_frame();
            for (int lt = 0; lt < 8; lt++)
              for (int ac = 0; ac < 2; ac++)
                for (int lv = 0; lv < 4; lv++) begin
                  line_type = lt[2:0]; active = ac[0]; lvl_sel = lv[1:0];
                  for (int c = 0; c < NCH; c++)
                    vid_in[c] = CW'((k * 397 + c * 613 + 1500) % 2048);
                  k++;
                  exp = model_all();
                  if (md == 0) tag = "R3 pc mode";
                  else if (!(ac == 1 && (VIDM[lt] || (ps == 1 && PASSM[lt]))))
                    tag = VIDM[lt] ? "R4 video line blanking" : "R6 level";
                  else if (bp == 1) tag = "R9 bypass";
                  else if (!VIDM[lt]) tag = "R5 passthrough";
                  else tag = "R7 offset";
                  step();
                  check(tag, exp);
                end
          end

    // R8: clamp boundary, PC mode, RGB, offset 300
    cfg_mode = 2'd0; cfg_rgb = 1'b1; cfg_bypass = 1'b0; cfg_offset = 11'd300;
    pulse_frame();
    vid_in[0] = 11'd1747; vid_in[1] = 11'd1746; vid_in[2] = 11'd2047;
    step();
    check("R8 clamp edge", {11'd2047, 11'd2046, 11'd2047});

    // R10: configuration change without frame pulse has no effect
    cfg_mode = 2'd2; cfg_pass = 1'b0;
    line_type = 3'd6; active = 1'b1; lvl_sel = 2'd2;
    vid_in[0] = 11'd10; vid_in[1] = 11'd20; vid_in[2] = 11'd30;
    step();
    step();
    check("R10 no pulse", {11'd330, 11'd320, 11'd310});
    pulse_frame();
    step();
    check("R10 after pulse", {csh, csh, ysh});

    // R6: reserved level code acts as blank
    lvl_sel = 2'd3;
    step();
    check("R6 code 3", {cb, cb, yb});

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule